// File: doc/BRIEF.md
# SPI Transaction Sequencer with Receive Skip

This block runs one SPI transaction from start to finish. Software writes a single 32-bit command word. That word picks one of four chip-select lines and gives the number of bytes to move. It also gives a count of leading received bytes to throw away. The sequencer then asks a separate bit-level shift engine for one byte at a time. It feeds that engine from the transmit FIFO and hands the received bytes to the receive FIFO. It raises a one-cycle done pulse after the last byte.

The receive-skip count is what makes a write-then-read transaction cheap. Command and address bytes are clocked out while the bytes that come back during that phase are dropped, so they never reach the receive FIFO. Once the skip count is non-zero, only the skipped bytes are taken from the transmit FIFO. Every byte after them is sent as zero and its received value is stored. Software therefore only has to load the command and address bytes.

The block also supports two flags. A transmit-only flag suppresses all receive storage. A dual-output flag marks the bytes after the skip phase so that the shift engine can drive two data lines.

Top module: `spi_xact_seq`

## Requirements
- R1: After reset, with no command, every chip-select output is high, `busy_o` is low and `done_o` is low. No byte is started and no FIFO is touched.
- R2: Command bits 31:30 select the chip-select line. Line `cs_n_o[k]` goes low for selection k and the other lines stay high. The selected line is low on every byte start and stays low for the whole transaction. All lines are high again in the cycle `done_o` is high.
- R3: Command bits 15:0 hold the byte count minus one. A value of L gives exactly L+1 byte starts before `done_o`.
- R4: Command bits 23:16 hold the skip count S. Received bytes with index below S are not pushed. Every later received byte is pushed, in order, with the value from the shift engine.
- R5: Transmit bytes come from the FIFO as follows:
  - With S = 0, every byte is popped from the transmit FIFO and sent unchanged.
  - With S > 0, only bytes with index below S are popped. Every later byte is sent as 0x00 with no pop.
- R6: When command bit 27 (transmit-only) is set, no received byte is pushed.
- R7: When command bit 28 (dual-output) is set, `byte_dual_o` is high on byte starts with index at or above S. It is low on all other byte starts.
- R8: `done_o` is high for exactly one cycle. That cycle is the one after the clock edge that takes the last `byte_done_i`.
- R9: A byte that needs FIFO data is not started, and nothing is popped, while `tx_empty_i` is high. The sequencer waits until data is present.
- R10: A command presented while `busy_o` is high is ignored. The running transaction keeps its chip select, length, skip count and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command write strobe |
| cmd_word_i | input | 32 | Command word |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle transaction-done event |
| cs_n_o | output | 4 | Active-low chip selects |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_data_i | input | 8 | Transmit FIFO head byte |
| tx_pop_o | output | 1 | Pop transmit FIFO |
| rx_push_o | output | 1 | Push receive FIFO |
| rx_data_o | output | 8 | Byte to push |
| byte_start_o | output | 1 | Start one byte in the shift engine |
| byte_tx_o | output | 8 | Byte to shift out, valid with start |
| byte_dual_o | output | 1 | Shift this byte on two lines, valid with start |
| byte_done_i | input | 1 | Shift engine finished the byte |
| byte_rx_i | input | 8 | Byte shifted in, valid with done |

## Verification
The bench targets the edges of the skip window. These cases are a skip count of zero, a skip of one, a skip equal to the length minus one, and a skip larger than the whole transaction.

A sequencer with an off-by-one compare would show up in two ways. It would push one stray address-phase byte or lose the first data byte. It would also pop a FIFO byte that software never loaded.

Single-byte and 255-skip transactions test the length decode and the last-byte detection. A wrong decode gives a byte count that is off by one, and a late detection gives a misplaced done pulse.

Random gaps in FIFO availability check that a byte is never started on stale data.

A second command is injected mid-transaction. A design that accepted it would switch the chip select or restart the byte count.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  localparam int unsigned CMD_W      = 32;
  localparam int unsigned NUM_CS     = 4;
  localparam int unsigned CS_W       = $clog2(NUM_CS);
  localparam int unsigned LEN_W      = 16;
  localparam int unsigned SKIP_W     = 8;
  localparam int unsigned DATA_W     = 8;

  // field positions software relies on
  localparam int unsigned CS_LSB     = 30;
  localparam int unsigned DUAL_BIT   = 28;
  localparam int unsigned TXONLY_BIT = 27;
  localparam int unsigned SKIP_LSB   = 16;
  localparam int unsigned LEN_LSB    = 0;

  typedef struct packed {
    logic [CS_W-1:0]   cs;
    logic              dual;
    logic              tx_only;
    logic [SKIP_W-1:0] skip;
    logic [LEN_W-1:0]  last_idx;
  } cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SHIFT = 2'd2
  } seq_st_e;

  function automatic cmd_t decode_cmd(input logic [CMD_W-1:0] w);
    cmd_t c;
    c.cs       = w[CS_LSB +: CS_W];
    c.dual     = w[DUAL_BIT];
    c.tx_only  = w[TXONLY_BIT];
    c.skip     = w[SKIP_LSB +: SKIP_W];
    c.last_idx = w[LEN_LSB +: LEN_W];
    return c;
  endfunction

endpackage

// File: rtl/spi_seq_cmd_reg.sv
module spi_seq_cmd_reg
  import spi_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CMD_W-1:0] word_i,
  output cmd_t             cmd_o
);

  cmd_t cmd_q;

  // bits with no meaning in the command
  logic unused_bits;
  assign unused_bits = ^{word_i[29], word_i[26:24]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '0;
    else if (load_i) cmd_q <= decode_cmd(word_i);
  end

  assign cmd_o = cmd_q;

  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && $past(!load_i) |-> $stable(cmd_q)) else $error("cmd changed"); // R10

endmodule

// File: rtl/spi_seq_byte_ctr.sv
module spi_seq_byte_ctr #(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned SKIP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [LEN_W-1:0]  last_idx_i,
  input  logic [SKIP_W-1:0] skip_i,
  output logic [LEN_W-1:0]  idx_o,
  output logic              last_o,
  output logic              in_skip_o
);

  localparam int unsigned CMP_W = (LEN_W > SKIP_W) ? LEN_W : SKIP_W;

  logic [LEN_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (clear_i) idx_q <= '0;
    else if (step_i)  idx_q <= idx_q + 1'b1;
  end

  assign idx_o     = idx_q;
  assign last_o    = (idx_q == last_idx_i);
  assign in_skip_o = CMP_W'(idx_q) < CMP_W'(skip_i);

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> idx_q < last_idx_i) else $error("index past end"); // R3

endmodule

// File: rtl/spi_seq_cs_drv.sv
module spi_seq_cs_drv #(
  parameter int unsigned NUM_CS = 4,
  localparam int unsigned CS_W  = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [CS_W-1:0]   sel_i,
  output logic [NUM_CS-1:0] cs_n_o
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n_o[g] = !(active_i && (sel_i == CS_W'(g)));
  end

  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o)) else $error("multiple cs"); // R2

  AST_CS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && $past(active_i) |-> $stable(cs_n_o)) else $error("cs moved"); // R2

endmodule

// File: rtl/spi_xact_seq.sv
module spi_xact_seq
  import spi_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [31:0]       cmd_word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [3:0]        cs_n_o,
  input  logic              tx_empty_i,
  input  logic [7:0]        tx_data_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [7:0]        rx_data_o,
  output logic              byte_start_o,
  output logic [7:0]        byte_tx_o,
  output logic              byte_dual_o,
  input  logic              byte_done_i,
  input  logic [7:0]        byte_rx_i
);

  seq_st_e          st_q, st_d;
  cmd_t             cmd;
  logic             accept, ctr_step, done_d, done_q;
  logic [LEN_W-1:0] idx;
  logic             last, in_skip, use_fifo, can_go, store;

  assign accept = (st_q == ST_IDLE) && cmd_valid_i;

  spi_seq_cmd_reg u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .word_i (cmd_word_i),
    .cmd_o  (cmd)
  );

  spi_seq_byte_ctr #(.LEN_W(LEN_W), .SKIP_W(SKIP_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .step_i     (ctr_step),
    .last_idx_i (cmd.last_idx),
    .skip_i     (cmd.skip),
    .idx_o      (idx),
    .last_o     (last),
    .in_skip_o  (in_skip)
  );

  spi_seq_cs_drv #(.NUM_CS(NUM_CS)) u_cs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (busy_o),
    .sel_i    (cmd.cs),
    .cs_n_o   (cs_n_o)
  );

  // skip mode feeds only the skipped bytes from the fifo; the rest go out as zero
  assign use_fifo = (cmd.skip == '0) || in_skip;
  assign can_go   = !use_fifo || !tx_empty_i;
  assign store    = !cmd.tx_only && !in_skip;

  always_comb begin
    st_d         = st_q;
    ctr_step     = 1'b0;
    byte_start_o = 1'b0;
    tx_pop_o     = 1'b0;
    rx_push_o    = 1'b0;
    done_d       = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (cmd_valid_i) st_d = ST_FETCH;
      ST_FETCH: if (can_go) begin
        byte_start_o = 1'b1;
        tx_pop_o     = use_fifo;
        st_d         = ST_SHIFT;
      end
      ST_SHIFT: if (byte_done_i) begin
        rx_push_o = store;
        if (last) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          ctr_step = 1'b1;
          st_d     = ST_FETCH;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign byte_tx_o   = use_fifo ? tx_data_i : '0;
  assign byte_dual_o = cmd.dual && !in_skip;
  assign rx_data_o   = byte_rx_i;

  logic unused_idx;
  assign unused_idx = ^idx;

  AST_POP_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> !tx_empty_i) else $error("pop on empty"); // R9

  AST_PUSH_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> byte_done_i && busy_o) else $error("stray push"); // R4

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done too long"); // R8

  AST_DONE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (&cs_n_o) && !busy_o) else $error("cs held at done"); // R2

  AST_DONE_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(byte_done_i)) else $error("done without byte"); // R8

endmodule

// File: tb/spi_xact_seq_bench.sv
module spi_xact_seq_bench;

  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [31:0] cmd_word_i = '0;
  logic        busy_o, done_o, tx_pop_o, rx_push_o, byte_start_o, byte_dual_o;
  logic [3:0]  cs_n_o;
  logic        tx_empty_i = 1'b1;
  logic [7:0]  tx_data_i = '0;
  logic [7:0]  rx_data_o, byte_tx_o;
  logic        byte_done_i = 1'b0;
  logic [7:0]  byte_rx_i = '0;

  spi_xact_seq u_spi_xact_seq (.*);

  initial forever #(CLK_P/2) clk_i = ~clk_i;

  int total = 0, bad = 0;
  int cyc = 0;

  logic [7:0] txq[$];
  logic [7:0] got_tx[$];
  bit         got_dual[$];
  logic [7:0] got_rx[$];
  int  pops, done_cnt, cs_bad, stall_bad, byte_k, fifo_n, done_cyc, last_done_cyc;
  bit  eng_busy = 0, gaps_on = 0;
  int  eng_d = 0;
  logic [7:0] salt = 0;
  logic [3:0] exp_cs_n = 4'hF;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rx_pat(input int k, input logic [7:0] s);
    return 8'(k * 13) + s;
  endfunction

  // FIFO and shift-engine model, driven at negedge, sampled shortly after
  initial forever begin
    @(negedge clk_i);
    cyc++;
    byte_done_i = 1'b0;
    if (eng_busy) begin
      if (eng_d == 0) begin
        byte_done_i   = 1'b1;
        byte_rx_i     = rx_pat(byte_k, salt);
        byte_k++;
        eng_busy      = 0;
        last_done_cyc = cyc;
      end else eng_d--;
    end
    tx_empty_i = (txq.size() == 0) || (gaps_on && ($urandom % 3 == 0));
    tx_data_i  = (txq.size() != 0) ? txq[0] : 8'h00;
    #1;
    if (rx_push_o) got_rx.push_back(rx_data_o);
    if (done_o) begin
      done_cnt++;
      done_cyc = cyc;
    end
    if (byte_start_o) begin
      got_tx.push_back(byte_tx_o);
      got_dual.push_back(byte_dual_o);
      if (cs_n_o != exp_cs_n) cs_bad++;
      if (tx_empty_i && byte_k < fifo_n) stall_bad++;
      eng_busy = 1;
      eng_d    = $urandom % 3;
    end
    if (busy_o && cs_n_o != exp_cs_n) cs_bad++;
    if (tx_pop_o) begin
      pops++;
      if (txq.size() != 0) void'(txq.pop_front());
    end
  end

  task automatic run_xact(input int cs, input int n, input int skip, input bit txonly,
                          input bit dual, input bit gaps, input bit inject);
    logic [7:0] data[$];
    int to;
    data.delete();
    got_tx.delete(); got_dual.delete(); got_rx.delete(); txq.delete();
    pops = 0; done_cnt = 0; cs_bad = 0; stall_bad = 0; byte_k = 0;
    done_cyc = -1; last_done_cyc = -100;
    salt     = 8'($urandom);
    gaps_on  = gaps;
    fifo_n   = (skip == 0) ? n : ((skip < n) ? skip : n);
    for (int i = 0; i < fifo_n; i++) begin
      data.push_back(8'($urandom));
      txq.push_back(data[i]);
    end
    exp_cs_n = ~(4'b0001 << cs);
    @(posedge clk_i); #2;
    cmd_word_i  = {2'(cs), 1'b0, dual, txonly, 3'b000, 8'(skip), 16'(n - 1)};
    cmd_valid_i = 1'b1;
    @(posedge clk_i); #2;
    cmd_valid_i = 1'b0;
    if (inject) begin
      repeat (3) @(posedge clk_i);
      #2;
      if (busy_o) begin
        cmd_word_i  = {2'(cs + 1), 1'b0, ~dual, ~txonly, 3'b000, 8'd0, 16'd3};
        cmd_valid_i = 1'b1;
        @(posedge clk_i); #2;
        cmd_valid_i = 1'b0;
      end
    end
    to = 0;
    while (done_cnt == 0 && to < 20000) begin
      @(posedge clk_i);
      to++;
    end
    repeat (3) @(posedge clk_i);
    #3;
    // R3 / R10: byte count
    check(got_tx.size() == n, "R3/R10 byte count", got_tx.size(), n);
    // R5: transmit data and pop count
    check(pops == fifo_n, "R5 pop count", pops, fifo_n);
    for (int k = 0; k < n && k < got_tx.size(); k++) begin
      logic [7:0] e;
      e = (k < fifo_n) ? data[k] : 8'h00;
      if (got_tx[k] !== e) begin
        check(0, $sformatf("R5 tx byte %0d", k), got_tx[k], e);
        break;
      end
      if (got_dual[k] !== (dual && k >= skip)) begin
        check(0, $sformatf("R7 dual byte %0d", k), got_dual[k], dual && k >= skip);
        break;
      end
    end
    // R4 / R6: received storage
    begin
      int ne;
      ne = txonly ? 0 : ((skip < n) ? n - skip : 0);
      check(got_rx.size() == ne, txonly ? "R6 rx count" : "R4 rx count", got_rx.size(), ne);
      for (int k = 0; k < ne && k < got_rx.size(); k++)
        if (got_rx[k] !== rx_pat(k + skip, salt)) begin
          check(0, $sformatf("R4 rx byte %0d", k), got_rx[k], rx_pat(k + skip, salt));
          break;
        end
    end
    check(cs_bad == 0, "R2/R10 chip select", cs_bad, 0);
    check(stall_bad == 0, "R9 start on empty", stall_bad, 0);
    check(done_cnt == 1, "R8 done count", done_cnt, 1);
    check(done_cyc == last_done_cyc + 1, "R8 done timing", done_cyc, last_done_cyc + 1);
    check(!busy_o && cs_n_o == 4'hF, "R1/R2 idle after done", {busy_o, cs_n_o}, 15);
    exp_cs_n = 4'hF;
    gaps_on  = 0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk_i);
    check(0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    #3;
    // R1 reset state
    check(cs_n_o == 4'hF && !busy_o && !done_o, "R1 reset outputs", {busy_o, done_o, cs_n_o}, 15);
    check(!byte_start_o && !tx_pop_o && !rx_push_o, "R1 reset idle", byte_start_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);
    #3;
    check(cs_n_o == 4'hF && !busy_o && !byte_start_o, "R1 idle no command", cs_n_o, 15);
    // directed corners
    run_xact(0, 1,   0,   0, 0, 0, 0);  // single byte
    run_xact(1, 8,   0,   0, 1, 1, 0);  // full duplex, dual, gaps
    run_xact(2, 8,   1,   0, 0, 0, 0);  // skip of one
    run_xact(3, 8,   7,   0, 1, 1, 0);  // skip = n-1
    run_xact(0, 5,   9,   0, 0, 0, 0);  // skip beyond length
    run_xact(1, 6,   2,   1, 0, 0, 0);  // tx only with skip
    run_xact(2, 300, 255, 0, 1, 1, 0);  // max skip
    run_xact(3, 20,  4,   0, 0, 0, 1);  // R10 mid-transaction command
    run_xact(0, 12,  0,   1, 0, 1, 1);  // R10 with tx only
    // random
    for (int t = 0; t < 30; t++) begin
      int n, s;
      n = 1 + ($urandom % 24);
      s = ($urandom % 2) ? 0 : ($urandom % (n + 3));
      run_xact($urandom % 4, n, s, ($urandom % 5) == 0, ($urandom % 4) == 0,
               $urandom % 2, ($urandom % 6) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule